// File: doc/BRIEF.md
# Asynchronous SRAM Sequencer

This block sits between a synchronous host and an asynchronous 16-bit static RAM. The RAM has two chip enables of opposite polarity, an active-low write strobe, an active-low output enable and one active-low enable per byte lane. The host offers one request at a time through a valid/ready handshake. Each request carries an address, write data, a per-lane mask and a read/write flag. The sequencer turns the request into a timed series of pin states and reports completion with a one-cycle done pulse. A read also returns its data on that pulse.

Four small counts set the timing in clock cycles. They are the output-enable access window, the write strobe length, the data hold after the strobe and the bus turnaround after each access. All four are sampled when a request is accepted. A count of zero is treated as one. Every pin to the RAM comes straight from a flip-flop. Between requests the RAM is left in standby.

Top module: `sram_seq_ctrl`

## Requirements
- R1: After reset, and on every cycle where `req_ready` is high, the RAM pins are in standby: `mem_ce1_n`=1, `mem_ce2`=0, `mem_we_n`=1, `mem_oe_n`=1, `mem_be_n`=all ones and `mem_dq_oe`=0.
- R2: In a read, `mem_oe_n` is low for exactly max(`cfg_rd_cycles`,1) cycles. During that window `mem_ce1_n`=0, `mem_ce2`=1, `mem_we_n`=1 and `mem_be_n` = bitwise NOT of the request mask. The data is captured in the last cycle of the window.
- R3: Mask bit 0 selects byte lane `[7:0]` and mask bit 1 selects lane `[15:8]`. In `rsp_rdata`, a lane that was not selected reads as zero.
- R4: In a write, `mem_oe_n` stays high while `mem_we_n` is low, and `mem_be_n` = NOT mask. Only the selected lanes of the addressed word change.
- R5: `mem_dq_oe` rises only in the cycle after `mem_we_n` has gone low. After `mem_we_n` rises, `mem_dq_oe` stays high for exactly max(`cfg_hold_cycles`,1) cycles, with address and data unchanged.
- R6: `mem_we_n` is low for exactly 1 + max(`cfg_wr_cycles`,1) cycles per write. The first of these cycles has the data drivers off.
- R7: `mem_addr` changes only when `mem_we_n` is high both in the cycle before the change and in the cycle of the change.
- R8: A request whose mask is all zeros gives `rsp_done` in the cycle after it is accepted. `req_ready` stays high and no chip-enable activation takes place.
- R9: After the done pulse of a RAM access, `req_ready` returns exactly max(`cfg_turn_cycles`,1) cycles later. The chip enables are inactive during that gap.
- R10: A count of zero behaves as a count of one in R2, R5, R6 and R9.
- R11: `mem_dq_oe` and a low `mem_oe_n` never occur in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Sequencer idle, able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Write data |
| req_mask | input | DW/8 | Per-lane select, bit 0 = low byte |
| cfg_rd_cycles | input | CW | Output-enable access window |
| cfg_wr_cycles | input | CW | Write strobe cycles with data driven |
| cfg_hold_cycles | input | CW | Data hold after strobe |
| cfg_turn_cycles | input | CW | Idle gap after each access |
| rsp_rdata | output | DW | Read result |
| rsp_done | output | 1 | One-cycle completion pulse |
| mem_addr | output | AW | RAM address |
| mem_ce1_n | output | 1 | RAM chip enable, active low |
| mem_ce2 | output | 1 | RAM chip enable, active high |
| mem_we_n | output | 1 | RAM write strobe, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_be_n | output | DW/8 | RAM lane enables, active low |
| mem_dq_out | output | DW | Data toward RAM |
| mem_dq_oe | output | 1 | Drive enable for `mem_dq_out` |
| mem_dq_in | input | DW | Data from RAM |

## Verification
The bench writes single lanes into one word and reads back each lane alone. A sequencer that ignored the mask would clobber the other byte or return its stale contents. Strobe, hold, access and turnaround lengths are measured at the pins under both zero and large counts. An off-by-one in the timer would show as a shortened window, and a missing clamp would show as a stuck or wrapped window. A RAM model stores garbage if the data drivers are off when the strobe ends, and mask-zero requests must finish without any chip-enable activation.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_RD,
    ST_WR_LEAD,
    ST_WR_PULSE,
    ST_WR_HOLD,
    ST_TURN
  } seq_state_e;

  typedef struct packed {
    logic ce1_n;
    logic ce2;
    logic we_n;
    logic oe_n;
    logic dq_oe;
    logic lanes_on;
  } pin_ctl_t;

  localparam pin_ctl_t PINS_PARK = '{ce1_n: 1'b1, ce2: 1'b0, we_n: 1'b1, oe_n: 1'b1,
                                     dq_oe: 1'b0, lanes_on: 1'b0};

  function automatic pin_ctl_t pins_for(seq_state_e s);
    pin_ctl_t p;
    p = '{ce1_n: 1'b0, ce2: 1'b1, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b0, lanes_on: 1'b1};
    case (s)
      ST_SETUP:    ;
      ST_RD:       p.oe_n = 1'b0;
      ST_WR_LEAD:  p.we_n = 1'b0;
      ST_WR_PULSE: begin p.we_n = 1'b0; p.dq_oe = 1'b1; end
      ST_WR_HOLD:  p.dq_oe = 1'b1;
      default:     p = PINS_PARK;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/sram_seq_timer.sv
module sram_seq_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= ONE;
    else if (load)          cnt_q <= (load_val == '0) ? ONE : load_val;
    else if (cnt_q > ONE)   cnt_q <= cnt_q - ONE;
  end

  assign expired = (cnt_q == ONE);

  // R10
  zero_count_clamp_chk: assert property (@(posedge clk) disable iff (rst)
    (load && load_val == '0) |=> expired);

endmodule

// File: rtl/sram_seq_lanes.sv
module sram_seq_lanes #(
  parameter int DW = 16
) (
  input  logic [DW/8-1:0] mask,
  input  logic [DW-1:0]   dq_in,
  output logic [DW/8-1:0] be_n,
  output logic [DW-1:0]   rd_masked
);
  for (genvar g = 0; g < DW/8; g++) begin : g_lane
    assign be_n[g]            = ~mask[g];
    assign rd_masked[g*8 +: 8] = mask[g] ? dq_in[g*8 +: 8] : 8'h00;
  end
endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
  import sram_seq_pkg::*;
#(
  parameter int AW = 18,
  parameter int DW = 16,
  parameter int CW = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic            req_write,
  input  logic [AW-1:0]   req_addr,
  input  logic [DW-1:0]   req_wdata,
  input  logic [DW/8-1:0] req_mask,
  input  logic [CW-1:0]   cfg_rd_cycles,
  input  logic [CW-1:0]   cfg_wr_cycles,
  input  logic [CW-1:0]   cfg_hold_cycles,
  input  logic [CW-1:0]   cfg_turn_cycles,
  output logic [DW-1:0]   rsp_rdata,
  output logic            rsp_done,
  output logic [AW-1:0]   mem_addr,
  output logic            mem_ce1_n,
  output logic            mem_ce2,
  output logic            mem_we_n,
  output logic            mem_oe_n,
  output logic [DW/8-1:0] mem_be_n,
  output logic [DW-1:0]   mem_dq_out,
  output logic            mem_dq_oe,
  input  logic [DW-1:0]   mem_dq_in
);
  localparam int LANES = DW / 8;

  seq_state_e       state_q, state_d;
  logic             write_q;
  logic [LANES-1:0] mask_q, mask_nx, lane_be_n;
  logic [DW-1:0]    rd_masked;
  logic [CW-1:0]    rd_q, wr_q, hold_q, turn_q, t_val;
  logic             t_load, t_exp, capture, done_d;
  logic             accept, zero_req;
  pin_ctl_t         pins_nx;

  assign accept   = req_valid && req_ready;
  assign zero_req = (req_mask == '0);
  assign mask_nx  = (accept && !zero_req) ? req_mask : mask_q;

  sram_seq_timer #(.CW(CW)) timer_i (
    .clk(clk), .rst(rst), .load(t_load), .load_val(t_val), .expired(t_exp)
  );

  sram_seq_lanes #(.DW(DW)) lanes_i (
    .mask(mask_nx), .dq_in(mem_dq_in), .be_n(lane_be_n), .rd_masked(rd_masked)
  );

  always_comb begin
    state_d = state_q;
    t_load  = 1'b0;
    t_val   = rd_q;
    capture = 1'b0;
    done_d  = 1'b0;
    case (state_q)
      ST_IDLE: if (accept) begin
        if (zero_req) done_d  = 1'b1;
        else          state_d = ST_SETUP;
      end
      ST_SETUP: begin
        if (write_q) state_d = ST_WR_LEAD;
        else begin state_d = ST_RD; t_load = 1'b1; t_val = rd_q; end
      end
      ST_RD: if (t_exp) begin
        state_d = ST_TURN; t_load = 1'b1; t_val = turn_q;
        capture = 1'b1;    done_d = 1'b1;
      end
      ST_WR_LEAD: begin state_d = ST_WR_PULSE; t_load = 1'b1; t_val = wr_q; end
      ST_WR_PULSE: if (t_exp) begin
        state_d = ST_WR_HOLD; t_load = 1'b1; t_val = hold_q;
      end
      ST_WR_HOLD: if (t_exp) begin
        state_d = ST_TURN; t_load = 1'b1; t_val = turn_q; done_d = 1'b1;
      end
      ST_TURN: if (t_exp) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  assign pins_nx = pins_for(state_d);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      req_ready  <= 1'b1;
      rsp_done   <= 1'b0;
      rsp_rdata  <= '0;
      write_q    <= 1'b0;
      mask_q     <= '0;
      rd_q       <= CW'(1);
      wr_q       <= CW'(1);
      hold_q     <= CW'(1);
      turn_q     <= CW'(1);
      mem_addr   <= '0;
      mem_dq_out <= '0;
      mem_ce1_n  <= 1'b1;
      mem_ce2    <= 1'b0;
      mem_we_n   <= 1'b1;
      mem_oe_n   <= 1'b1;
      mem_dq_oe  <= 1'b0;
      mem_be_n   <= '1;
    end else begin
      state_q   <= state_d;
      req_ready <= (state_d == ST_IDLE);
      rsp_done  <= done_d;
      if (capture) rsp_rdata <= rd_masked;
      if (accept && !zero_req) begin
        write_q    <= req_write;
        mask_q     <= req_mask;
        mem_addr   <= req_addr;
        mem_dq_out <= req_wdata;
        rd_q       <= cfg_rd_cycles;
        wr_q       <= cfg_wr_cycles;
        hold_q     <= cfg_hold_cycles;
        turn_q     <= cfg_turn_cycles;
      end
      mem_ce1_n <= pins_nx.ce1_n;
      mem_ce2   <= pins_nx.ce2;
      mem_we_n  <= pins_nx.we_n;
      mem_oe_n  <= pins_nx.oe_n;
      mem_dq_oe <= pins_nx.dq_oe;
      mem_be_n  <= pins_nx.lanes_on ? lane_be_n : '1;
    end
  end

  // R1
  idle_standby_chk: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (mem_ce1_n && !mem_ce2 && mem_we_n && mem_oe_n && !mem_dq_oe && mem_be_n == '1));

  // R2
  lanes_on_chk: assert property (@(posedge clk) disable iff (rst)
    !mem_ce1_n |-> (mem_be_n != '1));

  // R4
  strobe_oe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> mem_oe_n);

  // R5
  drive_after_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_dq_oe) |-> $past(!mem_we_n));

  // R7
  addr_change_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(mem_addr) |-> (mem_we_n && $past(mem_we_n)));

  // R8
  zero_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && zero_req) |=> (rsp_done && req_ready && mem_ce1_n));

  // R11
  no_contention_chk: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> mem_oe_n);

endmodule

// File: tb/sram_seq_ctrl_tb_top.sv
module sram_async_model #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic            clk,
  input  logic [AW-1:0]   addr,
  input  logic            ce1_n,
  input  logic            ce2,
  input  logic            we_n,
  input  logic            oe_n,
  input  logic [DW/8-1:0] be_n,
  input  logic [DW-1:0]   dq_out,
  input  logic            dq_oe,
  output logic [DW-1:0]   dq_in
);
  logic [DW-1:0] mem [0:(1<<AW)-1];
  logic          prev_wr;
  logic          wr_now;

  initial begin
    for (int i = 0; i < (1<<AW); i++) mem[i] = '0;
    prev_wr = 1'b0;
  end

  assign wr_now = !ce1_n && ce2 && !we_n;
  assign dq_in  = (!ce1_n && ce2 && !oe_n && we_n) ? mem[addr] : DW'(16'hBAD0);

  always @(negedge clk) begin
    prev_wr <= wr_now;
    if (prev_wr && !wr_now)
      for (int l = 0; l < DW/8; l++)
        if (!be_n[l]) mem[addr][l*8 +: 8] <= dq_oe ? dq_out[l*8 +: 8] : 8'hEE;
  end
endmodule

module sram_seq_ctrl_tb_top;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int CW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic          req_valid = 1'b0, req_write = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [1:0]    req_mask = '0;
  logic [CW-1:0] c_rd = 3, c_wr = 2, c_hold = 1, c_turn = 2;
  logic [DW-1:0] rsp_rdata, mem_dq_out, mem_dq_in;
  logic          rsp_done, mem_ce1_n, mem_ce2, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [AW-1:0] mem_addr;
  logic [1:0]    mem_be_n;

  sram_seq_ctrl #(.AW(AW), .DW(DW), .CW(CW)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
    .cfg_rd_cycles(c_rd), .cfg_wr_cycles(c_wr), .cfg_hold_cycles(c_hold), .cfg_turn_cycles(c_turn),
    .rsp_rdata(rsp_rdata), .rsp_done(rsp_done), .mem_addr(mem_addr), .mem_ce1_n(mem_ce1_n),
    .mem_ce2(mem_ce2), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_be_n(mem_be_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  sram_async_model #(.AW(AW), .DW(DW)) ram_i (
    .clk(clk), .addr(mem_addr), .ce1_n(mem_ce1_n), .ce2(mem_ce2), .we_n(mem_we_n),
    .oe_n(mem_oe_n), .be_n(mem_be_n), .dq_out(mem_dq_out), .dq_oe(mem_dq_oe), .dq_in(mem_dq_in)
  );

  typedef struct {
    bit            rd;
    bit            zero;
    logic [DW-1:0] exp;
    int            snap;
  } item_t;

  item_t         sb_q[$];
  logic [DW-1:0] shadow [0:(1<<AW)-1];
  int   n_cmp = 0, n_mis = 0;
  int   ce_falls = 0;
  logic [1:0] cur_mask = 2'b11;
  bit   finished = 0;

  function automatic int eff(logic [CW-1:0] v);
    return (v == 0) ? 1 : int'(v);
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    n_cmp++;
    if (!ok) begin
      n_mis++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit pins_parked();
    return mem_ce1_n && !mem_ce2 && mem_we_n && mem_oe_n && !mem_dq_oe && mem_be_n == 2'b11;
  endfunction

  task automatic issue(bit wr, logic [AW-1:0] a, logic [DW-1:0] d, logic [1:0] m);
    item_t it;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    it.rd   = !wr;
    it.zero = (m == 2'b00);
    it.snap = ce_falls;
    it.exp  = {m[1] ? shadow[a][15:8] : 8'h00, m[0] ? shadow[a][7:0] : 8'h00};
    if (wr) begin
      if (m[0]) shadow[a][7:0]  = d[7:0];
      if (m[1]) shadow[a][15:8] = d[15:8];
    end
    if (m != 2'b00) cur_mask = m;
    sb_q.push_back(it);
    req_write = wr; req_addr = a; req_wdata = d; req_mask = m; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic drain();
    @(negedge clk);
    while (sb_q.size() != 0 || !req_ready) @(negedge clk);
    @(negedge clk);
  endtask

  // pin monitor and scoreboard
  int   we_run = 0, oe_run = 0, hold_run = 0, turn_cnt = -1;
  logic prev_we_n = 1'b1, prev_dq_oe = 1'b0, prev_ce1_n = 1'b1;

  always @(negedge clk) begin
    if (!rst) begin
      if (!mem_ce1_n && prev_ce1_n) ce_falls++;
      // R11
      if (mem_dq_oe && !mem_oe_n) chk(0, "R11 contention", 1, 0);
      // R1
      if (req_ready && !pins_parked()) chk(0, "R1 parked while ready", 0, 1);
      // R4 / R6
      if (!mem_we_n) begin
        if (we_run == 0) begin
          chk(mem_be_n == ~cur_mask, "R4 lane enables on write", mem_be_n, ~cur_mask);
          chk(!mem_dq_oe, "R6 first strobe cycle undriven", mem_dq_oe, 0);
        end
        if (!mem_oe_n) chk(0, "R4 oe low during strobe", 0, 1);
        we_run++;
      end else if (we_run > 0) begin
        chk(we_run == 1 + eff(c_wr), "R6 strobe length", we_run, 1 + eff(c_wr));
        we_run = 0;
      end
      // R2
      if (!mem_oe_n) begin
        if (oe_run == 0)
          chk(mem_be_n == ~cur_mask && !mem_ce1_n && mem_ce2 && mem_we_n,
              "R2 read pin state", {mem_be_n, mem_ce1_n, mem_ce2, mem_we_n}, {~cur_mask, 3'b011});
        oe_run++;
      end else if (oe_run > 0) begin
        chk(oe_run == eff(c_rd), "R2 access window R10", oe_run, eff(c_rd));
        oe_run = 0;
      end
      // R5
      if (mem_dq_oe && !prev_dq_oe) chk(!prev_we_n, "R5 drivers after strobe", prev_we_n, 0);
      if (mem_dq_oe && mem_we_n) hold_run++;
      else if (hold_run > 0) begin
        chk(hold_run == eff(c_hold), "R5 hold length", hold_run, eff(c_hold));
        hold_run = 0;
      end
      // R9
      if (turn_cnt >= 0) begin
        if (req_ready) begin
          chk(turn_cnt == eff(c_turn), "R9 turnaround", turn_cnt, eff(c_turn));
          turn_cnt = -1;
        end else begin
          if (!mem_ce1_n || mem_ce2) chk(0, "R9 enables during turnaround", 0, 1);
          turn_cnt++;
        end
      end
      if (rsp_done) begin
        if (sb_q.size() == 0) chk(0, "R2 done with nothing pending", 1, 0);
        else begin
          item_t it;
          it = sb_q.pop_front();
          if (it.zero) begin
            chk(ce_falls == it.snap, "R8 no RAM cycle for empty mask", ce_falls, it.snap);
            chk(req_ready, "R8 stays ready", req_ready, 1);
          end else begin
            turn_cnt = 1;
            if (it.rd) chk(rsp_rdata == it.exp, "R3 read data lanes", rsp_rdata, it.exp);
          end
        end
      end
      prev_we_n  = mem_we_n;
      prev_dq_oe = mem_dq_oe;
      prev_ce1_n = mem_ce1_n;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      chk(0, "watchdog", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < (1<<AW); i++) shadow[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(pins_parked() && req_ready && !rsp_done, "R1 reset state",
        {mem_ce1_n, mem_ce2, mem_we_n, mem_oe_n, mem_dq_oe, req_ready}, 6'b101101);

    // R4 lane writes, R3 lane reads
    issue(1, 8'd5, 16'hA55A, 2'b11);
    issue(1, 8'd6, 16'h1234, 2'b01);
    issue(1, 8'd6, 16'hABCD, 2'b10);
    issue(0, 8'd5, 16'h0000, 2'b11);
    issue(0, 8'd6, 16'h0000, 2'b01);
    issue(0, 8'd6, 16'h0000, 2'b10);
    issue(0, 8'd6, 16'h0000, 2'b11);
    // R8 empty mask write is ignored, empty mask read completes
    issue(1, 8'd5, 16'hFFFF, 2'b00);
    issue(0, 8'd5, 16'h0000, 2'b00);
    issue(0, 8'd5, 16'h0000, 2'b11);
    drain();

    // R10 zero counts act as one
    c_rd = 0; c_wr = 0; c_hold = 0; c_turn = 0;
    issue(1, 8'd7, 16'h0F0F, 2'b11);
    issue(0, 8'd7, 16'h0000, 2'b11);
    issue(1, 8'd7, 16'hC3C3, 2'b10);
    issue(0, 8'd7, 16'h0000, 2'b11);
    drain();

    // long counts, back-to-back at changing addresses (R7)
    c_rd = 7; c_wr = 5; c_hold = 3; c_turn = 4;
    for (int i = 0; i < 16; i++)
      issue(1, AW'(i * 3 + 1), 16'(16'h1111 * i + 16'h0102), 2'(i % 3 + 1));
    for (int i = 0; i < 16; i++)
      issue(0, AW'(i * 3 + 1), 16'h0000, 2'(3 - (i % 3)));
    drain();

    c_rd = 15; c_wr = 1; c_hold = 15; c_turn = 1;
    issue(1, 8'd200, 16'hBEEF, 2'b11);
    issue(0, 8'd200, 16'h0000, 2'b01);
    issue(0, 8'd200, 16'h0000, 2'b11);
    drain();

    chk(pins_parked() && req_ready, "R1 parked at end",
        {mem_ce1_n, mem_ce2, mem_we_n, mem_oe_n}, 4'b1011);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
    $finish;
  end
endmodule